// File: doc/BRIEF.md
# Prescaled PWM Down-Counter Channel

This block is one pulse-width-modulated timer channel. The system clock passes through two divider stages. The first stage is a programmable 8-bit prescaler. The second is a power-of-two divider picked by a 3-bit select code. Together they produce a step pulse, and each step moves a 16-bit down counter by one. While the counter value is below an active compare value, the channel is in its active phase. That raw waveform is then inverted on request and gated by an output enable before it reaches the pin.

Software programs the channel through plain write strobes, one strobe per field group: prescale, divider select, period, compare, and a 5-bit control word. A period that has been written is not used until the counter next reloads, and the same holds for a compare value. As a result, a cycle that is already in progress always finishes with the settings it started with. The channel can run continuously in auto-reload mode or stop after one cycle in one-shot mode. At each period end it sets a sticky flag. Writing 1 to the flag clears it, and the flag drives the interrupt line when the interrupt enable is set.

Top module: `pwm_dcnt_channel`

## Requirements
- R1: After reset, count_val, period_flag, irq and pwm_out are all 0, and the period and compare registers hold 0.
- R2: In the running state, the counter moves once every (prescale+1)*D clock cycles. D is set by the divider select: code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 16, and code 4 or any higher code gives 1. One full PWM cycle therefore lasts (period+1)*(prescale+1)*D clock cycles.
- R3: On start, the counter loads the period. It then counts down by one per step to 0. In auto-reload mode (control bit 1 = 1), the step taken at 0 reloads the period. count_val always shows the current counter value.
- R4: The raw output is active while the counter is strictly below the active compare value C. Each cycle therefore contains min(C, period+1) active steps. C = 0 gives 0% duty, and C >= period+1 gives 100% duty.
- R5: A new period or compare value written while the channel runs has no effect on the cycle in progress. It is taken at the next reload.
- R6: In one-shot mode (control bit 1 = 0), the step taken at 0 sets the flag and stops the channel. The counter then stays at 0 and the output sits at its inactive level until the enable is cleared and set again.
- R7: A control write that takes bit 1 (auto-reload) from 0 to 1 clears both the period and compare registers. A control write that leaves bit 1 at 1 clears neither.
- R8: With control bit 0 (enable) at 0, the counter holds its value and both divider stages are cleared. When the enable is set again, the counter reloads the period one cycle after the control write. The first step then follows a full (prescale+1)*D cycles later.
- R9: pwm_out equals out_en AND (raw XOR invert). Here invert is control bit 2 and out_en is control bit 3. The raw output is inactive whenever the channel is not running.
- R10: period_flag is set at every period end, and a flag_clr pulse clears it. If a set and a clear fall in the same cycle, the set wins. irq equals period_flag AND the interrupt enable in control bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_psc_we | input | 1 | Write strobe for the prescale value |
| cfg_psc | input | 8 | Prescale value; stage one divides by value+1 |
| cfg_sel_we | input | 1 | Write strobe for the divider select |
| cfg_sel | input | 3 | Second-stage divider select code |
| cfg_per_we | input | 1 | Write strobe for the period |
| cfg_per | input | 16 | Period value (buffered until reload) |
| cfg_cmp_we | input | 1 | Write strobe for the compare value |
| cfg_cmp | input | 16 | Compare value (buffered until reload) |
| cfg_ctrl_we | input | 1 | Write strobe for the control word |
| cfg_ctrl | input | 5 | bit0 enable, bit1 auto-reload, bit2 invert, bit3 output enable, bit4 interrupt enable |
| flag_clr | input | 1 | Write-1 clear of the period flag |
| pwm_out | output | 1 | PWM pin |
| count_val | output | 16 | Live counter value |
| period_flag | output | 1 | Sticky period-end flag |
| irq | output | 1 | Period interrupt request |

## Verification
A register write takes effect at the clock edge where its strobe is sampled. A write to the control word that sets the enable loads the counter one edge after that. Each counter value then lasts (prescale+1)*D cycles. pwm_out follows the counter and compare registers without any extra register stage, and the flag rises at the same edge where the counter wraps. For these reasons, every input is driven at a falling edge and every result is sampled at the following falling edge or a later one. Duty and cycle length are measured between two flag sets, counting samples over exactly one window. Sequence checks count forward one falling edge per expected step from the first cycle after a write.

// File: rtl/pwm_dcnt_pkg.sv
package pwm_dcnt_pkg;

    localparam int CNT_W_DEF    = 16;
    localparam int PSC_W_DEF    = 8;
    localparam int SEL_W        = 3;
    localparam int DIV_LOG2_MAX = 4;
    localparam int LOG2_W       = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    // Control word, enable at bit 0 and interrupt enable at the top.
    typedef struct packed {
        logic irq_en;
        logic out_en;
        logic invert;
        logic autoreload;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // log2 of the second-stage division factor for a select code
    function automatic logic [LOG2_W-1:0] sel_to_log2(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 3'd1;
            3'd1:    return 3'd2;
            3'd2:    return 3'd3;
            3'd3:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_dcnt_regs.sv
module pwm_dcnt_regs
    import pwm_dcnt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PSC_W = PSC_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             psc_we,
    input  logic [PSC_W-1:0] psc_in,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_in,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             ctrl_we,
    input  ctrl_t            ctrl_in,
    input  logic             flag_clr,
    input  logic             period_end,
    output logic [PSC_W-1:0] psc_q,
    output logic [SEL_W-1:0] sel_q,
    output logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] cmp_q,
    output ctrl_t            ctrl_q,
    output logic             flag_q
);

    logic mode_rise;

    assign mode_rise = ctrl_we & ctrl_in.autoreload & ~ctrl_q.autoreload;

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_q  <= '0;
            sel_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (psc_we)  psc_q  <= psc_in;
            if (sel_we)  sel_q  <= sel_in;
            if (ctrl_we) ctrl_q <= ctrl_in;
        end
    end

    // Mode rising edge wipes period and compare ahead of any plain write.
    always_ff @(posedge clk) begin
        if (rst || mode_rise) begin
            per_q <= '0;
            cmp_q <= '0;
        end else begin
            if (per_we) per_q <= per_in;
            if (cmp_we) cmp_q <= cmp_in;
        end
    end

    // Sticky flag: a set beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst)             flag_q <= 1'b0;
        else if (period_end) flag_q <= 1'b1;
        else if (flag_clr)   flag_q <= 1'b0;
    end

endmodule

// File: rtl/pwm_dcnt_prescaler.sv
module pwm_dcnt_prescaler
    import pwm_dcnt_pkg::*;
#(
    parameter int PSC_W = PSC_W_DEF,
    parameter int DIV_W = DIV_LOG2_MAX
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);

    logic [PSC_W-1:0] pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;
    logic [DIV_W:0]   span;
    logic             pre_wrap;
    logic             div_wrap;

    always_comb begin
        span     = (DIV_W+1)'(1) << sel_to_log2(sel);
        div_last = DIV_W'(span - (DIV_W+1)'(1));
    end

    // >= keeps both stages bounded when a smaller value is written mid-count
    assign pre_wrap = (pre_cnt >= psc);
    assign div_wrap = (div_cnt >= div_last);
    assign step     = run & pre_wrap & div_wrap;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_wrap) begin
            pre_cnt <= '0;
            div_cnt <= div_wrap ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_dcnt_counter.sv
module pwm_dcnt_counter
    import pwm_dcnt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             autoreload,
    input  logic             step,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_cmp,
    output logic             run,
    output logic             period_end
);

    run_state_e state;
    logic       at_zero;

    assign at_zero    = (cnt == '0);
    assign run        = enable & (state == ST_RUN);
    assign period_end = run & step & at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            act_cmp <= '0;
        end else if (!enable) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt     <= per;
                    act_cmp <= cmp;
                    state   <= ST_RUN;
                end
                ST_RUN: begin
                    if (step) begin
                        if (!at_zero) begin
                            cnt <= cnt - 1'b1;
                        end else if (autoreload) begin
                            cnt     <= per;
                            act_cmp <= cmp;
                        end else begin
                            state <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

endmodule

// File: rtl/pwm_dcnt_outstage.sv
module pwm_dcnt_outstage #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic             invert,
    input  logic             out_en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_cmp,
    output logic             pwm
);

    logic raw;

    assign raw = run & (cnt < act_cmp);
    assign pwm = out_en & (raw ^ invert);

endmodule

// File: rtl/pwm_dcnt_channel.sv
module pwm_dcnt_channel
    import pwm_dcnt_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PSC_W = PSC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_psc_we,
    input  logic [PSC_W-1:0]  cfg_psc,
    input  logic              cfg_sel_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic              cfg_per_we,
    input  logic [CNT_W-1:0]  cfg_per,
    input  logic              cfg_cmp_we,
    input  logic [CNT_W-1:0]  cfg_cmp,
    input  logic              cfg_ctrl_we,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic              flag_clr,
    output logic              pwm_out,
    output logic [CNT_W-1:0]  count_val,
    output logic              period_flag,
    output logic              irq
);

    logic [PSC_W-1:0] psc_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] act_cmp;
    ctrl_t            ctrl_q;
    logic             ctl_en;
    logic             ctl_auto;
    logic             ctl_inv;
    logic             ctl_oe;
    logic             ctl_ie;
    logic             step;
    logic             run;
    logic             period_end;

    assign ctl_en   = ctrl_q.enable;
    assign ctl_auto = ctrl_q.autoreload;
    assign ctl_inv  = ctrl_q.invert;
    assign ctl_oe   = ctrl_q.out_en;
    assign ctl_ie   = ctrl_q.irq_en;

    pwm_dcnt_regs #(
        .CNT_W(CNT_W),
        .PSC_W(PSC_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .psc_we    (cfg_psc_we),
        .psc_in    (cfg_psc),
        .sel_we    (cfg_sel_we),
        .sel_in    (cfg_sel),
        .per_we    (cfg_per_we),
        .per_in    (cfg_per),
        .cmp_we    (cfg_cmp_we),
        .cmp_in    (cfg_cmp),
        .ctrl_we   (cfg_ctrl_we),
        .ctrl_in   (ctrl_t'(cfg_ctrl)),
        .flag_clr  (flag_clr),
        .period_end(period_end),
        .psc_q     (psc_q),
        .sel_q     (sel_q),
        .per_q     (per_q),
        .cmp_q     (cmp_q),
        .ctrl_q    (ctrl_q),
        .flag_q    (period_flag)
    );

    pwm_dcnt_prescaler #(
        .PSC_W(PSC_W),
        .DIV_W(DIV_LOG2_MAX)
    ) u_presc (
        .clk (clk),
        .rst (rst),
        .run (run),
        .psc (psc_q),
        .sel (sel_q),
        .step(step)
    );

    pwm_dcnt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctl_en),
        .autoreload(ctl_auto),
        .step      (step),
        .per       (per_q),
        .cmp       (cmp_q),
        .cnt       (count_val),
        .act_cmp   (act_cmp),
        .run       (run),
        .period_end(period_end)
    );

    pwm_dcnt_outstage #(
        .CNT_W(CNT_W)
    ) u_out (
        .run    (run),
        .invert (ctl_inv),
        .out_en (ctl_oe),
        .cnt    (count_val),
        .act_cmp(act_cmp),
        .pwm    (pwm_out)
    );

    assign irq = period_flag & ctl_ie;

endmodule

// File: rtl/pwm_dcnt_channel_chk.sv
module pwm_dcnt_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_en,
    input logic             ctl_auto,
    input logic             ctl_inv,
    input logic             ctl_oe,
    input logic             ctrl_we,
    input logic             ctrl_in_auto,
    input logic [CNT_W-1:0] per_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] act_cmp,
    input logic [CNT_W-1:0] count_val,
    input logic             pwm_out,
    input logic             step,
    input logic             run,
    input logic             period_end,
    input logic             period_flag,
    input logic             irq
);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> $stable(count_val)); // R8

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |-> (pwm_out == (ctl_oe & ctl_inv))); // R9

    AST_STEP_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (run && step && count_val != '0) |=> (count_val == $past(count_val) - 1'b1)); // R3

    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (rst)
        (period_end && !ctl_auto) |=> (count_val == '0)); // R6

    AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        period_end |=> period_flag); // R10

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> period_flag); // R10

    AST_MODE_WIPE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_in_auto && !ctl_auto) |=> (per_q == '0 && cmp_q == '0)); // R7

    AST_CMP_BUFFERED: assert property (@(posedge clk) disable iff (rst)
        (run && !(step && count_val == '0)) |=> $stable(act_cmp)); // R5

endmodule

bind pwm_dcnt_channel pwm_dcnt_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_en      (ctl_en),
    .ctl_auto    (ctl_auto),
    .ctl_inv     (ctl_inv),
    .ctl_oe      (ctl_oe),
    .ctrl_we     (cfg_ctrl_we),
    .ctrl_in_auto(cfg_ctrl[1]),
    .per_q       (per_q),
    .cmp_q       (cmp_q),
    .act_cmp     (act_cmp),
    .count_val   (count_val),
    .pwm_out     (pwm_out),
    .step        (step),
    .run         (run),
    .period_end  (period_end),
    .period_flag (period_flag),
    .irq         (irq)
);

// File: tb/pwm_dcnt_channel_tb.sv
`timescale 1ns/1ps
module pwm_dcnt_channel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_psc_we = 1'b0;
    logic [7:0]  cfg_psc = '0;
    logic        cfg_sel_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        cfg_per_we = 1'b0;
    logic [15:0] cfg_per = '0;
    logic        cfg_cmp_we = 1'b0;
    logic [15:0] cfg_cmp = '0;
    logic        cfg_ctrl_we = 1'b0;
    logic [4:0]  cfg_ctrl = '0;
    logic        flag_clr = 1'b0;
    logic        pwm_out;
    logic [15:0] count_val;
    logic        period_flag;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    pwm_dcnt_channel u_dut (
        .clk        (clk),
        .rst        (rst),
        .cfg_psc_we (cfg_psc_we),
        .cfg_psc    (cfg_psc),
        .cfg_sel_we (cfg_sel_we),
        .cfg_sel    (cfg_sel),
        .cfg_per_we (cfg_per_we),
        .cfg_per    (cfg_per),
        .cfg_cmp_we (cfg_cmp_we),
        .cfg_cmp    (cfg_cmp),
        .cfg_ctrl_we(cfg_ctrl_we),
        .cfg_ctrl   (cfg_ctrl),
        .flag_clr   (flag_clr),
        .pwm_out    (pwm_out),
        .count_val  (count_val),
        .period_flag(period_flag),
        .irq        (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int div_factor(input int sel);
        case (sel)
            0: return 2;
            1: return 4;
            2: return 8;
            3: return 16;
            default: return 1;
        endcase
    endfunction

    task automatic wr_psc(input int v);
        cfg_psc = 8'(v); cfg_psc_we = 1'b1; @(negedge clk); cfg_psc_we = 1'b0;
    endtask
    task automatic wr_sel(input int v);
        cfg_sel = 3'(v); cfg_sel_we = 1'b1; @(negedge clk); cfg_sel_we = 1'b0;
    endtask
    task automatic wr_per(input int v);
        cfg_per = 16'(v); cfg_per_we = 1'b1; @(negedge clk); cfg_per_we = 1'b0;
    endtask
    task automatic wr_cmp(input int v);
        cfg_cmp = 16'(v); cfg_cmp_we = 1'b1; @(negedge clk); cfg_cmp_we = 1'b0;
    endtask
    task automatic wr_ctrl(input bit en, input bit auto_m, input bit inv, input bit oe, input bit ie);
        cfg_ctrl = {ie, oe, inv, auto_m, en}; cfg_ctrl_we = 1'b1; @(negedge clk); cfg_ctrl_we = 1'b0;
    endtask
    task automatic clr_flag();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic wait_count(input int v);
        for (int g = 0; g < 5000; g++) begin
            if (count_val == 16'(v)) break;
            @(negedge clk);
        end
    endtask

    task automatic run_cfg(input int sel, input int psc, input int per, input int cmp,
                           input bit inv, input bit oe);
        wr_ctrl(1'b0, 1'b1, inv, oe, 1'b0);
        clr_flag();
        wr_sel(sel);
        wr_psc(psc);
        wr_per(per);
        wr_cmp(cmp);
        wr_ctrl(1'b1, 1'b1, inv, oe, 1'b0);
    endtask

    // Measures one full PWM cycle between two flag sets.
    task automatic measure(output int cyc, output int hi);
        cyc = 0;
        hi  = 0;
        for (int g = 0; g < 5000; g++) begin
            if (period_flag) break;
            @(negedge clk);
        end
        flag_clr = 1'b1;
        do begin
            if (pwm_out) hi++;
            cyc++;
            @(negedge clk);
            flag_clr = 1'b0;
        end while (!period_flag && cyc < 5000);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cyc, hi, n, c, v, hold, bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 count", int'(count_val), 0);
        chk("R1 flag", int'(period_flag), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 pwm", int'(pwm_out), 0);

        // R2/R4 sweep over divider codes, prescale values and compare values
        for (int s = 0; s < 6; s++) begin
            for (int p = 0; p < 3; p++) begin
                c = (s + p) % 5;
                run_cfg(s, p, 3, c, 1'b0, 1'b1);
                measure(cyc, hi);
                n = (p + 1) * div_factor(s);
                chk($sformatf("R2 cycle len sel=%0d psc=%0d", s, p), cyc, 4 * n);
                chk($sformatf("R4 duty sel=%0d psc=%0d cmp=%0d", s, p, c), hi,
                    ((c < 4) ? c : 4) * n);
            end
        end

        // R3 down count and auto-reload sequence
        run_cfg(4, 0, 5, 3, 1'b0, 1'b1);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk($sformatf("R3 count step %0d", k), int'(count_val), 5 - (k % 6));
        end

        // R5 period buffering
        wait_count(4);
        wr_per(2);
        chk("R5 count after period write", int'(count_val), 3);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk($sformatf("R5 count seq %0d", k), int'(count_val), (k < 3) ? 2 - k : 2 - ((k - 3) % 3));
        end

        // R5 compare buffering: period 2, compare 3 is full duty
        wr_cmp(3);
        wait_count(0);
        @(negedge clk);
        wait_count(2);
        wr_cmp(0);
        chk("R5 pwm keeps old cmp cnt1", int'(pwm_out), 1);
        @(negedge clk);
        chk("R5 pwm keeps old cmp cnt0", int'(pwm_out), 1);
        @(negedge clk);
        chk("R5 new cmp after reload cnt", int'(count_val), 2);
        chk("R5 new cmp after reload pwm", int'(pwm_out), 0);

        // R6 one-shot
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        clr_flag();
        wr_sel(4);
        wr_psc(0);
        wr_per(3);
        wr_cmp(2);
        wr_ctrl(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk($sformatf("R6 oneshot count %0d", k), int'(count_val), 3 - k);
        end
        repeat (10) @(negedge clk);
        chk("R6 parked count", int'(count_val), 0);
        chk("R6 flag set", int'(period_flag), 1);
        chk("R6 pwm inactive", int'(pwm_out), 0);
        chk("R10 irq enabled", int'(irq), 1);
        clr_flag();
        chk("R10 w1c clears flag", int'(period_flag), 0);
        chk("R6 no reload after clear", int'(count_val), 0);

        // R7 mode rising edge clears period and compare
        wr_ctrl(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wr_per(7);
        wr_cmp(5);
        wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R7 period wiped", int'(count_val), 0);
        chk("R7 compare wiped", int'(pwm_out), 0);
        wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        wr_per(7);
        wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R7 no wipe without edge", int'(count_val), 7);

        // R8 disable holds counter, prescaler restarts clean
        run_cfg(0, 2, 9, 0, 1'b0, 1'b1);
        wait_count(5);
        wr_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        v = int'(count_val);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (int'(count_val) != v || pwm_out) bad++;
        end
        chk("R8 hold while disabled", bad, 0);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        chk("R8 reload on re-enable", int'(count_val), 9);
        hold = 1;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (count_val != 16'd9) break;
            hold++;
        end
        chk("R8 first step after full prescale", hold, 6);

        // R9 invert and output enable
        wr_ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R9 idle level inverted", int'(pwm_out), 1);
        run_cfg(4, 0, 3, 2, 1'b1, 1'b1);
        measure(cyc, hi);
        chk("R9 inverted duty", hi, 2);
        run_cfg(4, 0, 3, 2, 1'b0, 1'b0);
        measure(cyc, hi);
        chk("R9 gated output", hi, 0);

        // R10 set wins over clear, irq masked by enable
        run_cfg(4, 0, 0, 0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk("R10 irq masked", int'(irq), 0);
        clr_flag();
        chk("R10 set wins over clear", int'(period_flag), 1);
        wr_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
        chk("R10 irq follows enable", int'(irq), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule